// File: doc/BRIEF.md
# Physical Port Auto-Selector for a 10 Mb/s Ethernet Endpoint

This block decides which of two physical attachments, a twisted-pair port or an AUI port, carries traffic for a 10 Mb/s Ethernet endpoint. It also drives the power enables of both ports. Two configuration bits choose the mode. In forced twisted-pair mode, only the twisted-pair port is used. In forced AUI mode, only the AUI port is used. In automatic mode, the block watches for activity on the twisted-pair receiver. That activity arrives as already-qualified link-pulse and valid-packet strobes.

In automatic mode, a quiet timer is reloaded by every strobe. While the timer is non-zero, the twisted-pair port stays selected. When the timer runs out, the block falls back to AUI, but the twisted-pair receiver stays powered so that it can still hear the line. Any later strobe reloads the timer and brings the selection back to twisted-pair with no software involvement. A selection change never happens in the middle of a frame. While the medium-busy input is high, the current port is held, and a pending change takes effect at the first idle cycle.

Top module: `phy_port_autosel`

## Requirements
- R1: While reset is asserted and directly after its release, twisted-pair is selected: `port_sel_aui`=0, `tp_pwr_en`=1, `aui_pwr_en`=0, `active_port`=2'b01.
- R2: With `cfg_aui_only`=0 and `cfg_auto_sel`=0 (forced twisted-pair), the idle block selects twisted-pair with the AUI unpowered, whatever strobes arrive and however long the line is quiet.
- R3: With `cfg_aui_only`=1 (forced AUI), whatever `cfg_auto_sel` holds, the idle block selects AUI, `aui_pwr_en`=1 and `tp_pwr_en`=0, and the strobes have no effect.
- R4: In automatic mode (`cfg_aui_only`=0, `cfg_auto_sel`=1), the timer is loaded with TIMEOUT_CYCLES at reset and at every clock edge that samples a strobe. It counts down on every other edge. The edge after it reaches zero selects AUI, which is TIMEOUT_CYCLES+1 edges after the last reload.
- R5: In automatic mode, `tp_pwr_en` stays 1 while AUI is selected.
- R6: In automatic mode with AUI selected, a link-pulse or valid-packet strobe sampled at edge k returns the selection to twisted-pair at edge k+1, provided the medium is idle.
- R7: A strobe that arrives before the timer expires restarts the full TIMEOUT_CYCLES window, so twisted-pair stays selected.
- R8: While `bus_busy`=1 the selection does not change, whether the change comes from the timer, from activity or from a mode write. The pending selection is applied at the first edge that samples `bus_busy`=0.
- R9: `active_port` is one-hot. Bit 0 means twisted-pair is active and bit 1 means AUI is active, and bit 1 always equals `aui_pwr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_aui_only | input | 1 | Forces AUI use when set |
| cfg_auto_sel | input | 1 | Enables automatic selection when the AUI-only bit is clear |
| tp_link_pulse | input | 1 | Qualified link-pulse strobe from the twisted-pair receiver |
| tp_pkt_valid | input | 1 | Qualified valid-packet strobe from the twisted-pair receiver |
| bus_busy | input | 1 | A receive or transmit is in progress |
| port_sel_aui | output | 1 | Port select: 0 means twisted-pair, 1 means AUI |
| tp_pwr_en | output | 1 | Twisted-pair transceiver power enable |
| aui_pwr_en | output | 1 | AUI power enable |
| active_port | output | 2 | One-hot active-port status {AUI, twisted-pair} |

## Verification
The automatic mode is tried in three ways. A fully quiet line shows the exact timeout edge. A single link pulse after fallback shows the two-edge return to twisted-pair. A valid-packet strobe arriving mid-window separates a true reload from a counter that merely pauses. Each forced mode is driven with strobes and long quiet stretches to show that activity and the timer are ignored there. Holding the busy input during both an activity-driven change and a mode write shows that the change waits for the frame to end rather than being dropped or applied early.

// File: rtl/phy_autosel_pkg.sv
package phy_autosel_pkg;

   typedef enum logic [1:0] {
      MODE_TP_FORCED  = 2'd0,
      MODE_AUI_FORCED = 2'd1,
      MODE_AUTO       = 2'd2
   } port_mode_e;

   typedef enum logic {
      PORT_TP  = 1'b0,
      PORT_AUI = 1'b1
   } port_e;

endpackage

// File: rtl/phy_autosel_mode_dec.sv
module phy_autosel_mode_dec
   import phy_autosel_pkg::*;
(
   input  logic       cfg_aui_only,
   input  logic       cfg_auto_sel,
   output port_mode_e mode
);

   always_comb begin
      if (cfg_aui_only)      mode = MODE_AUI_FORCED;
      else if (cfg_auto_sel) mode = MODE_AUTO;
      else                   mode = MODE_TP_FORCED;
   end

   always_comb begin
      a_aui_priority_r3 : assert (!cfg_aui_only || mode == MODE_AUI_FORCED);
   end

endmodule

// File: rtl/phy_autosel_quiet_timer.sv
module phy_autosel_quiet_timer
   import phy_autosel_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYCLES = 12_500_000,
   localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  port_mode_e mode,
   input  logic       activity,
   output logic       quiet
);

   localparam logic [CNT_W-1:0] LOAD = CNT_W'(TIMEOUT_CYCLES);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= LOAD;
      else if (mode != MODE_AUTO)   cnt_q <= LOAD;
      else if (activity)            cnt_q <= LOAD;
      else if (cnt_q != '0)         cnt_q <= cnt_q - 1'b1;
   end

   assign quiet = (cnt_q == '0);

   p_reload_clears_quiet_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_AUTO && activity) |=> !quiet);

   p_forced_never_quiet_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MODE_AUTO) |=> !quiet);

endmodule

// File: rtl/phy_autosel_switch.sv
module phy_autosel_switch
   import phy_autosel_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  port_mode_e mode,
   input  logic       quiet,
   input  logic       bus_busy,
   output port_e      sel_q
);

   port_e want;

   always_comb begin
      unique case (mode)
         MODE_AUI_FORCED: want = PORT_AUI;
         MODE_AUTO:       want = quiet ? PORT_AUI : PORT_TP;
         default:         want = PORT_TP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sel_q <= PORT_TP;
      else if (!bus_busy) sel_q <= want;
   end

   p_hold_while_busy_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      bus_busy |=> $stable(sel_q));

   p_forced_tp_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_TP_FORCED && !bus_busy) |=> sel_q == PORT_TP);

endmodule

// File: rtl/phy_port_autosel.sv
module phy_port_autosel
   import phy_autosel_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYCLES = 12_500_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_aui_only,
   input  logic       cfg_auto_sel,
   input  logic       tp_link_pulse,
   input  logic       tp_pkt_valid,
   input  logic       bus_busy,
   output logic       port_sel_aui,
   output logic       tp_pwr_en,
   output logic       aui_pwr_en,
   output logic [1:0] active_port
);

   if (TIMEOUT_CYCLES < 2) begin : g_bad_timeout
      $error("TIMEOUT_CYCLES must be at least 2");
   end

   port_mode_e mode;
   logic       quiet;
   logic       activity;
   port_e      sel;

   assign activity = tp_link_pulse | tp_pkt_valid;

   phy_autosel_mode_dec u_mode (
      .cfg_aui_only (cfg_aui_only),
      .cfg_auto_sel (cfg_auto_sel),
      .mode         (mode)
   );

   phy_autosel_quiet_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .activity (activity),
      .quiet    (quiet)
   );

   phy_autosel_switch u_switch (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .quiet    (quiet),
      .bus_busy (bus_busy),
      .sel_q    (sel)
   );

   assign port_sel_aui = (sel == PORT_AUI);
   assign aui_pwr_en   = port_sel_aui;
   assign tp_pwr_en    = !port_sel_aui || (mode == MODE_AUTO);
   assign active_port  = port_sel_aui ? 2'b10 : 2'b01;

   p_status_onehot_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      $countones(active_port) == 1 && active_port[1] == aui_pwr_en);

   p_listen_in_auto_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_AUTO && port_sel_aui) |-> tp_pwr_en);

   p_fallback_cause_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_sel_aui) |-> $past(mode == MODE_AUI_FORCED || quiet));

   p_activity_returns_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_AUTO && activity && !bus_busy) ##1 (mode == MODE_AUTO && !bus_busy)
      |=> !port_sel_aui);

   p_forced_aui_tp_off_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_AUI_FORCED && port_sel_aui) |-> !tp_pwr_en);

endmodule

// File: tb/test_phy_port_autosel.sv
module test_phy_port_autosel;

   localparam int T = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_aui_only = 1'b0;
   logic       cfg_auto_sel = 1'b1;
   logic       tp_link_pulse = 1'b0;
   logic       tp_pkt_valid = 1'b0;
   logic       bus_busy = 1'b0;
   logic       port_sel_aui;
   logic       tp_pwr_en;
   logic       aui_pwr_en;
   logic [1:0] active_port;

   always #4 clk = ~clk;

   phy_port_autosel #(.TIMEOUT_CYCLES(T)) i_phy_port_autosel (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_aui_only  (cfg_aui_only),
      .cfg_auto_sel  (cfg_auto_sel),
      .tp_link_pulse (tp_link_pulse),
      .tp_pkt_valid  (tp_pkt_valid),
      .bus_busy      (bus_busy),
      .port_sel_aui  (port_sel_aui),
      .tp_pwr_en     (tp_pwr_en),
      .aui_pwr_en    (aui_pwr_en),
      .active_port   (active_port)
   );

   typedef struct {
      string      req;
      logic       sel;
      logic       tp;
      logic       aui;
      logic [1:0] stat;
   } exp_t;

   exp_t q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 0;

   task automatic step(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic expect_tp(string req, logic tp_on);
      exp_t e;
      e.req = req; e.sel = 1'b0; e.tp = tp_on; e.aui = 1'b0; e.stat = 2'b01;
      q.push_back(e);
   endtask

   task automatic expect_aui(string req, logic tp_on);
      exp_t e;
      e.req = req; e.sel = 1'b1; e.tp = tp_on; e.aui = 1'b1; e.stat = 2'b10;
      q.push_back(e);
   endtask

   // monitor: compares queued expectations away from the active edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_cmp++;
         if ({port_sel_aui, tp_pwr_en, aui_pwr_en, active_port} !== {e.sel, e.tp, e.aui, e.stat}) begin
            n_bad++;
            $display("FAIL %s: sel/tp/aui/stat actual %b/%b/%b/%b expected %b/%b/%b/%b",
                     e.req, port_sel_aui, tp_pwr_en, aui_pwr_en, active_port,
                     e.sel, e.tp, e.aui, e.stat);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      step(2);
      expect_tp("R1 in reset", 1'b1);
      step();
      rst_n = 1'b1;
      step();
      expect_tp("R1 after release", 1'b1);

      // R4: quiet line, timer loaded at reset; one edge already used
      step(T - 1);
      expect_tp("R4 before timeout", 1'b1);
      step();
      expect_aui("R4 timeout to AUI, R5 tp listens", 1'b1);

      // R6: link pulse returns to twisted-pair after two edges
      tp_link_pulse = 1'b1;
      step();
      tp_link_pulse = 1'b0;
      expect_aui("R6 one edge after pulse", 1'b1);
      step();
      expect_tp("R6 back to twisted-pair", 1'b1);

      // R7: packet strobe mid-window restarts full window
      step(4);
      tp_pkt_valid = 1'b1;
      step();
      tp_pkt_valid = 1'b0;
      step(T);
      expect_tp("R7 reloaded window still twisted-pair", 1'b1);
      step();
      expect_aui("R7 expiry after reload", 1'b1);

      // R8: activity while busy is held until idle
      bus_busy = 1'b1;
      tp_link_pulse = 1'b1;
      step();
      tp_link_pulse = 1'b0;
      step(5);
      expect_aui("R8 held while busy", 1'b1);
      bus_busy = 1'b0;
      step();
      expect_tp("R8 applied at idle", 1'b1);

      // R2: forced twisted-pair ignores strobes and silence
      cfg_auto_sel = 1'b0;
      step();
      expect_tp("R2 forced twisted-pair", 1'b1);
      tp_link_pulse = 1'b1;
      step(2);
      tp_link_pulse = 1'b0;
      step(3 * T);
      expect_tp("R2 long quiet no fallback", 1'b1);

      // R3: forced AUI ignores strobes and auto bit
      cfg_aui_only = 1'b1;
      step();
      expect_aui("R3 forced AUI", 1'b0);
      tp_link_pulse = 1'b1;
      tp_pkt_valid = 1'b1;
      step(3);
      expect_aui("R3 strobes ignored", 1'b0);
      tp_link_pulse = 1'b0;
      tp_pkt_valid = 1'b0;
      cfg_auto_sel = 1'b1;
      step(2);
      expect_aui("R3 auto bit ignored", 1'b0);

      // R8: mode write while busy waits for idle
      bus_busy = 1'b1;
      cfg_aui_only = 1'b0;
      cfg_auto_sel = 1'b0;
      step(3);
      expect_aui("R8 mode change held", 1'b0);
      bus_busy = 1'b0;
      step();
      expect_tp("R8 mode change at idle", 1'b1);

      // R9 status and R5 via auto re-entry
      cfg_auto_sel = 1'b1;
      step(T + 1);
      expect_aui("R9 status one-hot AUI, R5", 1'b1);

      step();
      @(negedge clk);
      #1;
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule